// File: doc/BRIEF.md
# Event Output Selector and Stretcher

This block picks one event line out of a bundle of per-generator event bits and conditions it for use elsewhere on the chip and at a device pin. A single configuration register chooses the source generator and the signal within it. The same register sets how that signal is shaped: a minimum-width stretch counted in PWM clock enables, an optional resynchronisation to the system clock, an optional conversion into an exact two-clock pulse, the active level, and whether the result reaches the pin.

The event inputs come in as one flat vector, with 32 signal slots for each generator. The PWM clock is modelled as a one-cycle enable (`pwm_tick`) in the system clock domain. The conditioned event always drives the internal line `evt_int_o`. The pin output `evt_pin_o` carries the same value only when pin output is enabled. When pin output is disabled, the pin sits at the inactive level. The block moves no data stream, so every port is a plain control or status pin and there is no handshake.

Top module: `evt_out_cond`

## Requirements
- R1: Configuration bits [2:0] select the generator, where codes 0 to 3 mean generators 1 to 4. Bits [7:3] select the signal slot. The chosen line is `gen_evt[gen*32 + slot]`. Slot 0 is the externally supplied trigger-select line, slot 1 is the raw generator output, and any other input bit has no effect.
- R2: Generator codes 4 to 7 are reserved and give a constant inactive event. Slot codes 7, 12 to 25, 30 and 31 are also reserved and give the same result.
- R3: When bit [8] (stretch disable) is 0, a rising input edge makes the event active one clock later. The event then stays active until `pwm_tick` has been high on 8 later clock edges, or for as long as the input stays high, whichever is longer.
- R4: A new rising edge during an active stretch restarts the count of 8, so overlapping events merge into one continuous pulse.
- R5: When bits [8] and [9] are 1 and 0, the selected line passes to the output in the same cycle, with its width unchanged.
- R6: When bits [8] and [9] are both 1, each rising input edge passes through a two-flop synchroniser. It then produces an active pulse exactly two system clocks wide, starting three clock edges after the input rose, whatever the input width.
- R7: When bit [8] is 0 and bit [9] is 1, the event is first synchronised and then stretched. It becomes active three edges after the input rose.
- R8: When bit [10] is 1, both outputs are active-low. When it is 0, they are active-high.
- R9: When bit [11] is 0, `evt_pin_o` is held at the inactive level while `evt_int_o` still carries the event. When it is 1, the pin equals `evt_int_o`.
- R10: A configuration write with `cfg_we` takes effect from the following edge. Reset clears all 12 bits, which gives generator 1, slot 0, stretch on, no sync, active-high, and pin disabled.
- R11: Reset clears all shaping state at once, so both outputs go inactive during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 12 | Configuration value: [2:0] generator, [7:3] slot, [8] stretch disable, [9] sync, [10] active-low, [11] pin enable |
| gen_evt | input | N_GEN*32 | Event lines, 32 per generator |
| pwm_tick | input | 1 | PWM clock enable that paces the stretch count |
| evt_int_o | output | 1 | Conditioned internal event |
| evt_pin_o | output | 1 | Pin event, inactive level when pin output is disabled |

## Verification
Each result has a fixed latency. The pass-through event appears in the same cycle as the input. A stretched, non-synchronised event appears after one edge. Both synchronised paths appear after three edges. The two-clock pulse and the stretch last 2 and 8 cycles when `pwm_tick` is held high. The bench drives the inputs on the falling edge and samples the outputs 1 ns later. For each stimulus it records the sample index of the first active cycle and the number of active samples over a 40-cycle window, then compares both with those latencies and widths. A half-rate `pwm_tick` run checks that the stretch counts enables rather than clocks.

// File: rtl/evt_cond_pkg.sv
package evt_cond_pkg;

  localparam int SIGS_PER_GEN = 32;
  localparam int SLOT_W       = 5;
  localparam int GEN_W        = 3;
  localparam int CFG_W        = 12;

  typedef struct packed {
    logic              pin_en;
    logic              active_low;
    logic              sync_on;
    logic              stretch_off;
    logic [SLOT_W-1:0] slot;
    logic [GEN_W-1:0]  gen;
  } cfg_t;

  function automatic logic slot_code_ok(input logic [SLOT_W-1:0] c);
    return (c <= 5'd6) || ((c >= 5'd8) && (c <= 5'd11)) ||
           ((c >= 5'd26) && (c <= 5'd29));
  endfunction

  function automatic logic gen_code_ok(input logic [GEN_W-1:0] g, input int n_gen);
    return int'(g) < n_gen;
  endfunction

endpackage

// File: rtl/evt_src_mux.sv
module evt_src_mux
  import evt_cond_pkg::*;
#(
  parameter int N_GEN = 4
) (
  input  logic [N_GEN*SIGS_PER_GEN-1:0] gen_evt,
  input  logic [GEN_W-1:0]              gen_sel,
  input  logic [SLOT_W-1:0]             slot_sel,
  output logic                          evt_o
);
  localparam int IDX_W = (N_GEN > 1) ? $clog2(N_GEN) : 1;

  logic [SIGS_PER_GEN-1:0] bank [N_GEN];

  for (genvar g = 0; g < N_GEN; g++) begin : g_bank
    assign bank[g] = gen_evt[g*SIGS_PER_GEN +: SIGS_PER_GEN];
  end

  always_comb begin
    evt_o = 1'b0;
    if (gen_code_ok(gen_sel, N_GEN) && slot_code_ok(slot_sel))
      evt_o = bank[gen_sel[IDX_W-1:0]][slot_sel];
  end
endmodule

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/evt_pulse_shaper.sv
module evt_pulse_shaper #(
  parameter int LEN  = 8,
  parameter bit HOLD = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  input  logic tick_i,
  output logic pulse_o
);
  localparam int CNT_W = $clog2(LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             in_q;
  logic             rise;

  assign rise = in_i & ~in_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      in_q  <= 1'b0;
    end else begin
      in_q <= in_i;
      if (rise)
        cnt_q <= CNT_W'(LEN);
      else if (tick_i && (cnt_q != '0))
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pulse_o = (cnt_q != '0) | (HOLD & in_q);

  // R4: count never exceeds its reload value
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LEN));

  if (LEN >= 2) begin : g_chk
    // R3 (and R6 for the two-clock instance): no single-cycle output pulse
    assert_no_glitch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_o) |=> pulse_o);
  end
endmodule

// File: rtl/evt_out_cond.sv
module evt_out_cond
  import evt_cond_pkg::*;
#(
  parameter int N_GEN       = 4,
  parameter int STRETCH_LEN = 8,
  parameter int SYNC_PULSE  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CFG_W-1:0]              cfg_wdata,
  input  logic [N_GEN*SIGS_PER_GEN-1:0] gen_evt,
  input  logic                          pwm_tick,
  output logic                          evt_int_o,
  output logic                          evt_pin_o
);
  cfg_t cfg_q;
  logic mux_evt, sync_evt, stretch_in, stretch_evt, two_evt, cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
  end

  evt_src_mux #(.N_GEN(N_GEN)) u_mux (
    .gen_evt  (gen_evt),
    .gen_sel  (cfg_q.gen),
    .slot_sel (cfg_q.slot),
    .evt_o    (mux_evt)
  );

  evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (mux_evt),
    .q_o   (sync_evt)
  );

  assign stretch_in = cfg_q.sync_on ? sync_evt : mux_evt;

  evt_pulse_shaper #(.LEN(STRETCH_LEN), .HOLD(1'b1)) u_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_i    (stretch_in),
    .tick_i  (pwm_tick),
    .pulse_o (stretch_evt)
  );

  evt_pulse_shaper #(.LEN(SYNC_PULSE), .HOLD(1'b0)) u_two (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_i    (sync_evt),
    .tick_i  (1'b1),
    .pulse_o (two_evt)
  );

  always_comb begin
    if (!cfg_q.stretch_off)  cond = stretch_evt;
    else if (cfg_q.sync_on)  cond = two_evt;
    else                     cond = mux_evt;
  end

  assign evt_int_o = cond ^ cfg_q.active_low;
  assign evt_pin_o = cfg_q.pin_en ? evt_int_o : cfg_q.active_low;

  // R2: reserved codes leave the selected line quiet
  assert_reserved_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(gen_code_ok(cfg_q.gen, N_GEN) && slot_code_ok(cfg_q.slot)) |-> !mux_evt);

  // R6: two-clock mode pulses last beyond their first cycle
  assert_two_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.sync_on && cfg_q.stretch_off && !cfg_we && $rose(cond)) |=> cond);

  // R9: a disabled pin does not move while the configuration is steady
  assert_pin_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.pin_en && $stable(cfg_q)) |-> $stable(evt_pin_o));
endmodule

// File: tb/evt_out_cond_tb_top.sv
module evt_out_cond_tb_top;
  localparam int CLK_NS = 10;
  localparam int NG = 4;
  localparam int GW = NG * 32;
  localparam int NV = 14;
  // {cfg[11:0], pattern[15:0], drive index, first active sample, active width}
  localparam logic [51:0] VEC [0:NV-1] = '{
    {12'h908, 16'h0007, 8'd1,   8'd0,   8'd3},
    {12'h808, 16'h0001, 8'd1,   8'd1,   8'd8},
    {12'hB4A, 16'h0001, 8'd73,  8'd3,   8'd2},
    {12'hB4A, 16'h003F, 8'd73,  8'd3,   8'd2},
    {12'hAEB, 16'h0001, 8'd125, 8'd3,   8'd8},
    {12'h808, 16'h0FFF, 8'd1,   8'd1,   8'd12},
    {12'h808, 16'h0011, 8'd1,   8'd1,   8'd12},
    {12'hD31, 16'h0003, 8'd38,  8'd0,   8'd2},
    {12'h90C, 16'h00FF, 8'd255, 8'd255, 8'd0},
    {12'h960, 16'h00FF, 8'd255, 8'd255, 8'd0},
    {12'h9F0, 16'h00FF, 8'd255, 8'd255, 8'd0},
    {12'h908, 16'h0001, 8'd33,  8'd255, 8'd0},
    {12'h900, 16'h0003, 8'd0,   8'd0,   8'd2},
    {12'hFD9, 16'h0001, 8'd59,  8'd3,   8'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, pwm_tick = 1'b1;
  logic [11:0] cfg_wdata = '0;
  logic [GW-1:0] gen_evt = '0;
  logic evt_int, evt_pin;
  int n_run = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  evt_out_cond dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .gen_evt(gen_evt), .pwm_tick(pwm_tick),
    .evt_int_o(evt_int), .evt_pin_o(evt_pin)
  );

  function automatic string req_of(input int v);
    case (v)
      0: return "R5 pass-through";
      1: return "R3 stretch";
      2, 3: return "R6 two-clock pulse";
      4: return "R7 sync then stretch";
      5: return "R3 long input";
      6: return "R4 retrigger merge";
      7: return "R8 active-low";
      8, 9, 10: return "R2 reserved code";
      11: return "R1 other bit ignored";
      12: return "R1 trigger-select slot";
      default: return "R8 R6 active-low two-clock";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [11:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_pulse(input logic [15:0] pat, input int drv, input bit half,
                           input bit al, output int fi, output int wi,
                           output int fp, output int wp);
    logic [GW-1:0] m;
    m = (drv == 255) ? '1 : ({{(GW-1){1'b0}}, 1'b1} << drv);
    fi = -1; wi = 0; fp = -1; wp = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      gen_evt  = (k < 16 && pat[k]) ? m : '0;
      pwm_tick = half ? (k % 2 == 1) : 1'b1;
      #1;
      if (evt_int ^ al) begin if (fi < 0) fi = k; wi++; end
      if (evt_pin ^ al) begin if (fp < 0) fp = k; wp++; end
    end
    gen_evt = '0; pwm_tick = 1'b1;
  endtask

  initial begin : watchdog
    #(CLK_NS * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int fi, wi, fp, wp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(evt_int == 1'b0, "R10 reset int level", evt_int, 0);
    chk(evt_pin == 1'b0, "R10 reset pin level", evt_pin, 0);

    // default config: generator 1, slot 0, stretch on, pin disabled
    run_pulse(16'h0001, 0, 1'b0, 1'b0, fi, wi, fp, wp);
    chk(wi == 8, "R10 default stretch width", wi, 8);
    chk(fi == 1, "R10 default stretch start", fi, 1);
    chk(wp == 0, "R9 pin disabled stays idle", wp, 0);

    for (int v = 0; v < NV; v++) begin
      logic [11:0] c;
      c = VEC[v][51:40];
      write_cfg(c);
      idle(4);
      run_pulse(VEC[v][39:24], int'(VEC[v][23:16]), 1'b0, c[10], fi, wi, fp, wp);
      chk(wi == int'(VEC[v][7:0]), req_of(v), wi, int'(VEC[v][7:0]));
      chk(wp == wi, {req_of(v), " pin width"}, wp, wi);
      if (VEC[v][7:0] != 0)
        chk(fi == int'(VEC[v][15:8]), {req_of(v), " start"}, fi, int'(VEC[v][15:8]));
      idle(2);
    end

    // R8 with R9: active-low, pin disabled -> pin constant high, int pulses low
    write_cfg(12'h400);
    idle(2); #1;
    chk(evt_pin == 1'b1, "R9 disabled pin at inactive-high", evt_pin, 1);
    chk(evt_int == 1'b1, "R8 idle active-low level", evt_int, 1);
    run_pulse(16'h0001, 0, 1'b0, 1'b1, fi, wi, fp, wp);
    chk(wi == 8, "R8 active-low stretched width", wi, 8);
    chk(wp == 0, "R9 disabled pin never active", wp, 0);

    // R3: stretch counts pwm_tick enables, not clocks
    write_cfg(12'h808);
    idle(4);
    run_pulse(16'h0001, 1, 1'b1, 1'b0, fi, wi, fp, wp);
    chk(wi == 15, "R3 half-rate tick width", wi, 15);

    // R11: reset during an active stretch
    @(negedge clk); gen_evt[1] = 1'b1;
    @(negedge clk); gen_evt = '0;
    @(negedge clk); #1;
    chk(evt_pin == 1'b1, "R3 stretch active before reset", evt_pin, 1);
    rst_n = 1'b0; #1;
    chk(evt_int == 1'b0, "R11 int cleared in reset", evt_int, 0);
    chk(evt_pin == 1'b0, "R11 pin cleared in reset", evt_pin, 0);
    @(negedge clk); rst_n = 1'b1;
    // R10: after reset slot is 0, so bit 1 is ignored
    run_pulse(16'h0001, 1, 1'b0, 1'b0, fi, wi, fp, wp);
    chk(wi == 0, "R10 reset slot ignores bit 1", wi, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule